// File: doc/BRIEF.md
# Row Command Packet Decoder

This block sits behind the three-lane row control bus of a packet-driven DRAM interface. Each lane carries one bit per half-cycle, and the block receives both half-cycle samples of every clock as two 3-bit words: `row_early` and `row_late`. The block collects the 8 bit-times of each 24-bit row packet. It recognises the start of a packet from its framing code, checks whether the packet is addressed to this device, and turns the packet into single-cycle command strobes that carry their bank and row fields.

Two kinds of packet exist. An activate packet names a bank and a row. An operation packet carries an 11-bit opcode that can combine a bank command (precharge, refresh-activate or refresh-precharge) with a low-power command and a relax or attention request. An operation packet can instead carry a temperature-calibration request. For refresh-activate the row comes from an internal 9-bit refresh row counter instead of from the packet. The counter advances after the highest bank is refreshed.

Top module: `row_packet_decoder`

## Requirements
- R1: A packet starts at the first bit-time, early half before late half, in which lane 2 or lane 1 is 1. That start can fall in either half of a clock. The packet then takes 8 consecutive bit-times. Its strobes are high during the one clock that follows the clock edge on which the last bit-time was sampled. A bit-time in which only lane 0 is 1 does not start a packet.
- R2: The framing lanes are ignored until all 8 bit-times of a packet are captured. A new packet can start in the late half of the clock whose early half held the previous packet's last bit-time.
- R3: Bit-time 0 carries the select code {lane2, lane1}. The packet matches this device as follows. Code 11 is broadcast and always matches. Code 01 matches when `dev_id` equals {0, d3..d0}. Code 10 matches when `dev_id` equals {1, d3..d0}. Here d3 is lane 0 of bit-time 0, and d2..d0 are lanes 2..0 of bit-time 1. An unmatched packet gives no strobe.
- R4: The bank b4..b0 is carried as b0,b1,b2 on lanes 2,1,0 of bit-time 2, and b3,b4 on lanes 2,1 of bit-time 3. Lane 0 of bit-time 4 is the kind bit: 1 means activate, 0 means operation. In an activate packet, bit-times 5 to 7 carry row bits 8..0, lanes 2..0, in order. An activate gives `act_o` with `bank_o` and `row_o`. Lane 0 of bit-time 3 is reserved and is ignored. In an activate packet, lanes 2 and 1 of bit-time 4 are also reserved and ignored.
- R5: In an operation packet, the opcode o10..o0 is carried as o10,o9 on lanes 2,1 of bit-time 4, followed by bit-times 5 to 7 (lanes 2..0). Both bank commands below require o2..o0 = 000. If o10..o6 = 11000, `pre_o` pulses. If o10..o6 = 10101 and o5..o4 = 00, `refp_o` pulses.
- R6: If o10..o6 = 00011, o5..o4 = 00 and o2..o0 = 000, `refa_o` pulses and `row_o` shows the refresh counter. The counter resets to 0. It increments after a refresh-activate whose bank is 31 and holds its value for any other bank.
- R7: If o2..o0 = 000 and o10..o6 is 00000 or 11000, then o5..o4 selects a low-power strobe: 01 gives `pdn_o`, 10 gives `nap_o`, 11 gives `napc_o`. If o2..o0 = 000 and o3 = 1, `relax_o` pulses. Any of these can be combined with a precharge in one opcode.
- R8: `attn_o` pulses for a non-broadcast activate. It also pulses for a non-broadcast operation with o3 = 0, o2..o0 = 000 and a non-zero opcode. It never pulses for a broadcast packet.
- R9: If o10..o3 are all 0, then o2..o0 = 001 gives `tcal_o` and o2..o0 = 010 gives `tcen_o`. An all-zero opcode gives no strobe. Other non-zero values of o2..o0 give no strobe.
- R10: While `rst_n` is low, all strobes are 0, the refresh counter is 0, and any partly captured packet is discarded.
- R11: No strobe is high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 5 | This device's address |
| row_early | input | 3 | Lane bits of the first half-cycle, lanes 2..0 |
| row_late | input | 3 | Lane bits of the second half-cycle, lanes 2..0 |
| act_o | output | 1 | Activate strobe |
| pre_o | output | 1 | Precharge strobe |
| refa_o | output | 1 | Refresh-activate strobe |
| refp_o | output | 1 | Refresh-precharge strobe |
| pdn_o | output | 1 | Power-down strobe |
| nap_o | output | 1 | Nap strobe |
| napc_o | output | 1 | Conditional nap strobe |
| relax_o | output | 1 | Relax (standby) strobe |
| attn_o | output | 1 | Attention strobe |
| tcal_o | output | 1 | Temperature calibrate strobe |
| tcen_o | output | 1 | Temperature calibrate-enable strobe |
| bank_o | output | 5 | Bank of the last matched packet |
| row_o | output | 9 | Row of the last matched packet (refresh counter for refresh-activate) |
| bcast_o | output | 1 | Last matched packet was a broadcast |

## Verification
The case that needs care is a packet's last bit-time and the next packet's framing bit arriving in the same clock. In that clock, completion and re-alignment happen together. The bench sends a packet that starts in a late half and follows it with no gap, so the second packet frames in the late half of the clock whose early half ended the first packet. It then checks that both packets produce their own strobes, banks and rows in the expected clocks, with a quiet clock between them. A second coincidence is checked separately: a refresh-activate on bank 31 reports the old counter value in the same clock that the counter advances. The bench checks this through the rows reported by later refresh-activates.

// File: rtl/row_packet_decoder.sv
module row_packet_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] dev_id,
  input  logic [2:0] row_early,
  input  logic [2:0] row_late,
  output logic       act_o,
  output logic       pre_o,
  output logic       refa_o,
  output logic       refp_o,
  output logic       pdn_o,
  output logic       nap_o,
  output logic       napc_o,
  output logic       relax_o,
  output logic       attn_o,
  output logic       tcal_o,
  output logic       tcen_o,
  output logic [4:0] bank_o,
  output logic [8:0] row_o,
  output logic       bcast_o
);
  localparam int BT = 8;

  logic [3:0]       cnt, cnt_n;
  logic [7:0][2:0]  cap, cap_n, pkt;
  logic             done;
  logic [2:0]       bt;
  logic [8:0]       ref_row;
  logic [10:0]      stb_q;
  logic [4:0]       bank_q;
  logic [8:0]       row_q;
  logic             bc_q;

  always_comb begin
    cnt_n = cnt;
    cap_n = cap;
    done  = 1'b0;
    pkt   = '0;
    bt    = '0;
    for (int h = 0; h < 2; h++) begin
      bt = (h == 0) ? row_early : row_late;
      if (cnt_n == 4'd0) begin
        if (bt[2] | bt[1]) begin
          cap_n[0] = bt;
          cnt_n    = 4'd1;
        end
      end else begin
        cap_n[cnt_n[2:0]] = bt;
        cnt_n = cnt_n + 4'd1;
      end
      if (cnt_n == 4'(BT)) begin
        done  = 1'b1;
        pkt   = cap_n;
        cnt_n = 4'd0;
      end
    end
  end

  wire [1:0]  sel   = {pkt[0][2], pkt[0][1]};
  wire [3:0]  dr    = {pkt[0][0], pkt[1]};
  wire [4:0]  bank  = {pkt[3][1], pkt[3][2], pkt[2][0], pkt[2][1], pkt[2][2]};
  wire        av    = pkt[4][0];
  wire [8:0]  arow  = {pkt[5], pkt[6], pkt[7]};
  wire [10:0] op    = {pkt[4][2], pkt[4][1], pkt[5], pkt[6], pkt[7]};

  wire bc    = (sel == 2'b11);
  wire hit   = done && (bc || (sel == 2'b01 && dev_id == {1'b0, dr})
                           || (sel == 2'b10 && dev_id == {1'b1, dr}));
  wire is_op = hit && !av;
  wire low0  = (op[2:0] == 3'b000);
  wire nolp  = (op[5:4] == 2'b00);

  wire d_act  = hit && av;
  wire d_pre  = is_op && low0 && op[10:6] == 5'b11000;
  wire d_refa = is_op && low0 && nolp && op[10:6] == 5'b00011;
  wire d_refp = is_op && low0 && nolp && op[10:6] == 5'b10101;
  wire pwr_ok = is_op && low0 && (op[10:6] == 5'b00000 || op[10:6] == 5'b11000);
  wire d_pdn  = pwr_ok && op[5:4] == 2'b01;
  wire d_nap  = pwr_ok && op[5:4] == 2'b10;
  wire d_napc = pwr_ok && op[5:4] == 2'b11;
  wire d_rlx  = is_op && low0 && op[3];
  wire d_attn = hit && !bc && (av || (low0 && !op[3] && |op[10:4]));
  wire d_tcal = is_op && op[10:3] == 8'd0 && op[2:0] == 3'b001;
  wire d_tcen = is_op && op[10:3] == 8'd0 && op[2:0] == 3'b010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cap     <= '0;
      stb_q   <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      bc_q    <= 1'b0;
      ref_row <= '0;
    end else begin
      cnt   <= cnt_n;
      cap   <= cap_n;
      stb_q <= {d_act, d_pre, d_refa, d_refp, d_pdn, d_nap, d_napc,
                d_rlx, d_attn, d_tcal, d_tcen};
      if (hit) begin
        bank_q <= bank;
        row_q  <= av ? arow : ref_row;
        bc_q   <= bc;
      end
      if (d_refa && bank == 5'h1f)
        ref_row <= ref_row + 9'd1;
    end
  end

  assign {act_o, pre_o, refa_o, refp_o, pdn_o, nap_o, napc_o,
          relax_o, attn_o, tcal_o, tcen_o} = stb_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign bcast_o = bc_q;
endmodule

module row_packet_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] stb,
  input logic [4:0]  bank_o,
  input logic [8:0]  row_o,
  input logic        bcast_o,
  input logic [8:0]  ref_row
);
  wire s_act = stb[10], s_pre = stb[9], s_refa = stb[8], s_refp = stb[7];
  wire s_attn = stb[2], s_tcal = stb[1], s_tcen = stb[0];

  p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    |stb |=> !(|stb));
  p_bank_cmd_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_pre, s_refa, s_refp}));
  p_act_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_act |-> (stb[9:3] == 7'd0 && stb[1:0] == 2'd0));
  p_no_bcast_attn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_o && |stb) |-> !s_attn);
  p_refcnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_row != $past(ref_row)) |-> (s_refa && bank_o == 5'h1f && ref_row == $past(ref_row) + 9'd1));
  p_refa_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_refa |-> row_o == $past(ref_row));
  p_tc_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tcal && s_tcen));
endmodule

bind row_packet_decoder row_packet_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .stb({act_o, pre_o, refa_o, refp_o, pdn_o, nap_o, napc_o, relax_o, attn_o, tcal_o, tcen_o}),
  .bank_o(bank_o), .row_o(row_o), .bcast_o(bcast_o), .ref_row(ref_row)
);

// File: tb/tb_row_packet_decoder.sv
module tb_row_packet_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] dev_id = 5'b10110;
  logic [2:0] row_early = '0, row_late = '0;
  logic act_o, pre_o, refa_o, refp_o, pdn_o, nap_o, napc_o, relax_o, attn_o, tcal_o, tcen_o;
  logic [4:0] bank_o;
  logic [8:0] row_o;
  logic bcast_o;

  always #10 clk = ~clk;

  row_packet_decoder dut (.*);

  wire [10:0] stb = {act_o, pre_o, refa_o, refp_o, pdn_o, nap_o, napc_o,
                     relax_o, attn_o, tcal_o, tcen_o};

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [10:0] stb_s [0:11];
  logic [4:0]  bank_s [0:11];
  logic [8:0]  row_s [0:11];
  logic        bc_s [0:11];

  typedef struct packed {
    logic [1:0]  code;
    logic [3:0]  dr;
    logic [4:0]  bk;
    logic        av;
    logic [10:0] pay;
    logic [2:0]  rsv;
    logic        late;
    logic [10:0] exp;
    logic [3:0]  req;
  } vec_t;

  // strobe order: act pre refa refp pdn nap napc relax attn tcal tcen
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 4'b0110, 5'd5,  1'b1, 11'h1A5,        3'b111, 1'b0, 11'b10000000100, 4'd4}, // R4 R3
    '{2'b01, 4'b0110, 5'd5,  1'b1, 11'h1A5,        3'b000, 1'b0, 11'b00000000000, 4'd3}, // R3
    '{2'b11, 4'b0000, 5'd17, 1'b1, 11'h0C3,        3'b000, 1'b0, 11'b10000000000, 4'd8}, // R8
    '{2'b00, 4'b1001, 5'd4,  1'b1, 11'h049,        3'b000, 1'b0, 11'b00000000000, 4'd1}, // R1
    '{2'b10, 4'b0110, 5'd9,  1'b0, 11'b11000000000, 3'b001, 1'b0, 11'b01000000100, 4'd5}, // R5
    '{2'b10, 4'b0110, 5'd2,  1'b0, 11'b11000111000, 3'b000, 1'b0, 11'b01000011000, 4'd7}, // R7
    '{2'b10, 4'b0110, 5'd0,  1'b0, 11'b00000010000, 3'b000, 1'b0, 11'b00001000100, 4'd7}, // R7
    '{2'b10, 4'b0110, 5'd0,  1'b0, 11'b00000101000, 3'b000, 1'b0, 11'b00000101000, 4'd7}, // R7
    '{2'b10, 4'b0110, 5'd0,  1'b0, 11'b00000000001, 3'b000, 1'b0, 11'b00000000010, 4'd9}, // R9
    '{2'b10, 4'b0110, 5'd0,  1'b0, 11'b00000000010, 3'b000, 1'b0, 11'b00000000001, 4'd9}, // R9
    '{2'b10, 4'b0110, 5'd0,  1'b0, 11'b00000000000, 3'b000, 1'b0, 11'b00000000000, 4'd9}, // R9
    '{2'b11, 4'b1111, 5'd0,  1'b0, 11'b00000010000, 3'b000, 1'b0, 11'b00001000000, 4'd8}, // R8
    '{2'b10, 4'b0110, 5'd30, 1'b0, 11'b11000000000, 3'b000, 1'b1, 11'b01000000100, 4'd1}, // R1
    '{2'b10, 4'b0110, 5'd21, 1'b0, 11'b10101000000, 3'b000, 1'b0, 11'b00010000100, 4'd5}, // R5
    '{2'b10, 4'b0110, 5'd0,  1'b0, 11'b00000000011, 3'b000, 1'b0, 11'b00000000000, 4'd9}  // R9
  };

  function automatic logic [23:0] mkpkt(input logic [1:0] code, input logic [3:0] dr,
      input logic [4:0] bk, input logic av, input logic [10:0] pay, input logic [2:0] rsv);
    logic [23:0] p;
    p[2:0]   = {code[1], code[0], dr[3]};
    p[5:3]   = dr[2:0];
    p[8:6]   = {bk[0], bk[1], bk[2]};
    p[11:9]  = {bk[3], bk[4], rsv[0]};
    p[14:12] = av ? {rsv[2], rsv[1], 1'b1} : {pay[10], pay[9], 1'b0};
    p[17:15] = pay[8:6];
    p[20:18] = pay[5:3];
    p[23:21] = pay[2:0];
    return p;
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive_bits(input logic [59:0] s, input int np);
    for (int j = 0; j <= np + 1; j++) begin
      @(negedge clk);
      stb_s[j] = stb; bank_s[j] = bank_o; row_s[j] = row_o; bc_s[j] = bcast_o;
      if (j < np) begin
        row_early = s[6*j +: 3];
        row_late  = s[6*j+3 +: 3];
      end else begin
        row_early = '0;
        row_late  = '0;
      end
    end
  endtask

  task automatic send(input logic [23:0] p, input logic late, output int slot);
    logic [59:0] s = '0;
    if (late) begin s[26:3] = p; drive_bits(s, 5); slot = 5; end
    else      begin s[23:0] = p; drive_bits(s, 4); slot = 4; end
  endtask

  task automatic refa_case(input logic [4:0] bk, input logic [8:0] exp_row, input string what);
    int sl;
    send(mkpkt(2'b10, 4'b0110, bk, 1'b0, 11'b00011000000, 3'b000), 1'b0, sl);
    check(6, {what, " strobes"}, 32'(stb_s[sl]), 32'(11'b00100000100)); // R6
    check(6, {what, " row"}, 32'(row_s[sl]), 32'(exp_row));             // R6
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int sl;
    repeat (3) @(negedge clk);
    check(10, "reset strobes", 32'(stb), 0);        // R10
    check(10, "reset fields", 32'({bank_o, row_o}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(mkpkt(VEC[i].code, VEC[i].dr, VEC[i].bk, VEC[i].av, VEC[i].pay, VEC[i].rsv), VEC[i].late, sl);
      check(VEC[i].req, $sformatf("vec%0d strobes", i), 32'(stb_s[sl]), 32'(VEC[i].exp));
      check(11, $sformatf("vec%0d next clock quiet", i), 32'(stb_s[sl+1]), 0); // R11
      if (VEC[i].exp != 0) begin
        check(4, $sformatf("vec%0d bank", i), 32'(bank_s[sl]), 32'(VEC[i].bk));
        check(3, $sformatf("vec%0d broadcast flag", i), 32'(bc_s[sl]), 32'(VEC[i].code == 2'b11));
        if (VEC[i].av)
          check(4, $sformatf("vec%0d row", i), 32'(row_s[sl]), 32'(VEC[i].pay[8:0]));
      end
    end

    // R6 refresh counter: starts at 0, advances only after bank 31
    refa_case(5'd3,  9'd0, "refa b3 first");
    refa_case(5'd31, 9'd0, "refa b31 first");
    refa_case(5'd3,  9'd1, "refa b3 after wrap");
    refa_case(5'd31, 9'd1, "refa b31 second");
    refa_case(5'd0,  9'd2, "refa b0 third");

    // R2 back-to-back: late-started packet ends in the clock the next one frames
    begin
      logic [59:0] s = '0;
      s[26:3]  = mkpkt(2'b10, 4'b0110, 5'd7,  1'b1, 11'h0F0, 3'b000);
      s[50:27] = mkpkt(2'b10, 4'b0110, 5'd12, 1'b0, 11'b11000000000, 3'b000);
      drive_bits(s, 9);
      check(2, "b2b first strobes", 32'(stb_s[5]), 32'(11'b10000000100));
      check(2, "b2b first row", 32'(row_s[5]), 32'h0F0);
      check(11, "b2b gap quiet", 32'(stb_s[6]), 0);
      check(2, "b2b second strobes", 32'(stb_s[9]), 32'(11'b01000000100));
      check(2, "b2b second bank", 32'(bank_s[9]), 32'd12);
    end

    // R10 reset mid-packet discards the partial capture
    begin
      logic [23:0] p = mkpkt(2'b10, 4'b0110, 5'd14, 1'b1, 11'h155, 3'b000);
      @(negedge clk); row_early = p[2:0]; row_late = p[5:3];
      @(negedge clk); row_early = p[8:6]; row_late = p[11:9];
      @(negedge clk); row_early = '0; row_late = '0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check(10, "reset clears strobes", 32'(stb), 0);
      send(mkpkt(2'b10, 4'b0110, 5'd11, 1'b0, 11'b11000000000, 3'b000), 1'b0, sl);
      check(10, "packet after reset strobes", 32'(stb_s[sl]), 32'(11'b01000000100));
      check(10, "packet after reset bank", 32'(bank_s[sl]), 32'd11);
      refa_case(5'd3, 9'd0, "refa after reset");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule